// File: doc/BRIEF.md
# Chained Watchpoint and Counter Unit

This block turns a vector of comparator hits into eleven watchpoints. Each watchpoint takes a primary input and, according to a two-bit link code, stands alone, is ANDed with the watchpoint below it, is ORed with it, or is switched off. The links cascade within a single evaluation, so a chain of several stages settles in one step.

The first eight watchpoints take their primary input from comparator hits. The next two take it from a counter-equals-match test on one of two 16-bit counters. The last one takes it from an external hit line.

The evaluation strobe latches the new watchpoint vector. A watchpoint that rises on that evaluation (set now, clear in the stored vector) bumps the counter it is assigned to, if that counter is enabled. If its mask bit is set, it also raises a one-cycle breakpoint request. Both counters and both match values can be loaded from outside.

Top module: `wpc_unit`

## Requirements
- R1: After reset, `wp_o`, `bp_req_o`, both counters and both match values are zero.
- R2: The link code of watchpoint n is `wp_mode_i[2n+1:2n]`. Code 0 gives the primary input alone. Code 1 gives the primary input AND the link term. Code 2 gives the primary input OR the link term. Code 3 gives no match. The link term of watchpoint n>0 is the result of watchpoint n-1 in the same evaluation. For watchpoint 0, the link term is `hit_i[0]`.
- R3: The primary input of watchpoint n (n<8) is `hit_i[n]`. For watchpoint 8 it is counter 0 equal to match 0. For watchpoint 9 it is counter 1 equal to match 1. Both compares use the values held before the evaluation. For watchpoint 10 it is `hit_i[8]`.
- R4: When `eval_i` is high at a clock edge, `wp_o` shows the new watchpoint vector after that edge. When `eval_i` is low, `wp_o` holds its value.
- R5: On an evaluation, each rising watchpoint n adds one to counter 1 if `cnt_sel_i[n]`=1, and to counter 0 otherwise. A counter k changes only if `cnt_en_i[k]` is set. Counters wrap modulo 2^16. A watchpoint that stays set adds nothing.
- R6: `bp_req_o` is high for the one cycle after an evaluation in which some rising watchpoint n has `bp_mask_i[n]` set. Otherwise it is low.
- R7: `cnt_wr_i[k]` loads `cnt_val_i` into counter k at the next edge. This load overrides any increment in that cycle. `match_wr_i[k]` loads `match_val_i` into match value k.
- R8: Without `eval_i`, neither counter changes except by a load, and `bp_req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eval_i | input | 1 | Evaluation strobe |
| hit_i | input | 9 | Comparator hits [7:0], external hit [8] |
| wp_mode_i | input | 22 | Two-bit link code per watchpoint |
| cnt_sel_i | input | 11 | Counter assignment per watchpoint (1 = counter 1) |
| cnt_en_i | input | 2 | Counter enables |
| bp_mask_i | input | 11 | Breakpoint mask per watchpoint |
| cnt_wr_i | input | 2 | Counter load strobes |
| cnt_val_i | input | 16 | Counter load value |
| match_wr_i | input | 2 | Match load strobes |
| match_val_i | input | 16 | Match load value |
| wp_o | output | 11 | Stored watchpoint vector |
| bp_req_o | output | 1 | Breakpoint request pulse |
| cnt0_o | output | 16 | Counter 0 |
| cnt1_o | output | 16 | Counter 1 |
| match0_o | output | 16 | Match value 0 |
| match1_o | output | 16 | Match value 1 |

## Verification
Every result is registered exactly once. The watchpoint vector, the breakpoint pulse, the counters and the match values all change at the first edge after the evaluation or load that caused them. The bench drives all inputs on a falling edge and computes the expected state from its own model of the inputs in place at that moment. It compares every output at the next falling edge, which leaves one full rising edge between cause and sample. Because the counter compares feed watchpoints 8 and 9 from pre-edge values, the model updates its counters only after it has computed the chain.

// File: rtl/wpc_pkg.sv
`timescale 1ns/1ps
package wpc_pkg;
  typedef enum logic [1:0] {
    LINK_SOLO = 2'd0,
    LINK_AND  = 2'd1,
    LINK_OR   = 2'd2,
    LINK_OFF  = 2'd3
  } link_e;

  function automatic logic link_eval(input logic [1:0] code, input logic own, input logic lnk);
    case (link_e'(code))
      LINK_SOLO: return own;
      LINK_AND:  return own & lnk;
      LINK_OR:   return own | lnk;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic int unsigned rise_count(input logic [31:0] rise, input logic [31:0] pick);
    int unsigned s;
    s = 0;
    for (int i = 0; i < 32; i++) s += {31'd0, rise[i] & pick[i]};
    return s;
  endfunction
endpackage

// File: rtl/wpc_chain.sv
`timescale 1ns/1ps
module wpc_chain #(
  parameter int NUM_CMP = 8,
  localparam int NUM_WP = NUM_CMP + 3
) (
  input  logic [NUM_CMP:0]    hit_i,
  input  logic [1:0]          cnt_eq_i,
  input  logic [2*NUM_WP-1:0] wp_mode_i,
  output logic [NUM_WP-1:0]   wp_now_o
);
  import wpc_pkg::*;

  logic [NUM_WP-1:0] own_in;

  always_comb begin
    for (int n = 0; n < NUM_WP; n++) begin
      if (n < NUM_CMP)       own_in[n] = hit_i[n];
      else if (n == NUM_CMP) own_in[n] = cnt_eq_i[0];
      else if (n == NUM_CMP + 1) own_in[n] = cnt_eq_i[1];
      else                   own_in[n] = hit_i[NUM_CMP];
    end
  end

  always_comb begin
    logic lnk;
    lnk = hit_i[0];
    for (int n = 0; n < NUM_WP; n++) begin
      wp_now_o[n] = link_eval(wp_mode_i[2*n +: 2], own_in[n], lnk);
      lnk = wp_now_o[n];
    end
  end
endmodule

// File: rtl/wpc_counter.sv
`timescale 1ns/1ps
module wpc_counter #(
  parameter int CW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] inc_i,
  input  logic          en_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_val_i,
  input  logic          match_wr_i,
  input  logic [CW-1:0] match_val_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] match_o,
  output logic          eq_o
);
  logic bump;
  assign bump = en_i && (inc_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o   <= '0;
      match_o <= '0;
    end else begin
      if (cnt_wr_i)  cnt_o <= cnt_val_i;
      else if (bump) cnt_o <= cnt_o + CW'(inc_i);
      if (match_wr_i) match_o <= match_val_i;
    end
  end

  assign eq_o = (cnt_o == match_o);

  // R8: no increment and no load leaves the counter alone
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bump && !cnt_wr_i) |=> $stable(cnt_o));
  // R7: a load wins over an increment
  a_r7_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> (cnt_o == $past(cnt_val_i)));
endmodule

// File: rtl/wpc_unit.sv
`timescale 1ns/1ps
module wpc_unit #(
  parameter int NUM_CMP = 8,
  parameter int CW      = 16,
  localparam int NUM_WP = NUM_CMP + 3,
  localparam int IW     = $clog2(NUM_WP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eval_i,
  input  logic [NUM_CMP:0]    hit_i,
  input  logic [2*NUM_WP-1:0] wp_mode_i,
  input  logic [NUM_WP-1:0]   cnt_sel_i,
  input  logic [1:0]          cnt_en_i,
  input  logic [NUM_WP-1:0]   bp_mask_i,
  input  logic [1:0]          cnt_wr_i,
  input  logic [CW-1:0]       cnt_val_i,
  input  logic [1:0]          match_wr_i,
  input  logic [CW-1:0]       match_val_i,
  output logic [NUM_WP-1:0]   wp_o,
  output logic                bp_req_o,
  output logic [CW-1:0]       cnt0_o,
  output logic [CW-1:0]       cnt1_o,
  output logic [CW-1:0]       match0_o,
  output logic [CW-1:0]       match1_o
);
  import wpc_pkg::*;

  logic [NUM_WP-1:0] wp_now;
  logic [NUM_WP-1:0] wp_rise;
  logic [1:0]        cnt_eq;
  logic [IW-1:0]     inc [2];
  logic [CW-1:0]     cnt_q [2];
  logic [CW-1:0]     match_q [2];
  logic              bp_hit;

  wpc_chain #(.NUM_CMP(NUM_CMP)) u_chain (
    .hit_i     (hit_i),
    .cnt_eq_i  (cnt_eq),
    .wp_mode_i (wp_mode_i),
    .wp_now_o  (wp_now)
  );

  assign wp_rise = eval_i ? (wp_now & ~wp_o) : '0;
  assign bp_hit  = |(wp_rise & bp_mask_i);

  always_comb begin
    inc[0] = IW'(rise_count(32'(wp_rise), 32'(~cnt_sel_i)));
    inc[1] = IW'(rise_count(32'(wp_rise), 32'(cnt_sel_i)));
  end

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    wpc_counter #(.CW(CW), .IW(IW)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_i       (inc[k]),
      .en_i        (cnt_en_i[k]),
      .cnt_wr_i    (cnt_wr_i[k]),
      .cnt_val_i   (cnt_val_i),
      .match_wr_i  (match_wr_i[k]),
      .match_val_i (match_val_i),
      .cnt_o       (cnt_q[k]),
      .match_o     (match_q[k]),
      .eq_o        (cnt_eq[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_o     <= '0;
      bp_req_o <= 1'b0;
    end else begin
      if (eval_i) wp_o <= wp_now;
      bp_req_o <= bp_hit;
    end
  end

  assign cnt0_o   = cnt_q[0];
  assign cnt1_o   = cnt_q[1];
  assign match0_o = match_q[0];
  assign match1_o = match_q[1];

  // R4: the stored vector only moves on an evaluation
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(wp_o));
  // R8: no evaluation, no request
  a_r8_no_bp: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> !bp_req_o);
  // R6: a request comes from a masked watchpoint that is now set
  a_r6_bp_source: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req_o |-> |(wp_o & $past(bp_mask_i)));
  // R2: code 3 on watchpoint 0 never stores a match
  a_r2_off: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && wp_mode_i[1:0] == 2'd3) |=> !wp_o[0]);
endmodule

// File: tb/tb_wpc_unit.sv
`timescale 1ns/1ps
module tb_wpc_unit;
  localparam int NW = 11;

  logic clk = 0, rst_n = 0, eval_i = 0;
  logic [8:0] hit_i = '0;
  logic [2*NW-1:0] wp_mode_i = '1;
  logic [NW-1:0] cnt_sel_i = '0, bp_mask_i = '0;
  logic [1:0] cnt_en_i = '0, cnt_wr_i = '0, match_wr_i = '0;
  logic [15:0] cnt_val_i = '0, match_val_i = '0;
  logic [NW-1:0] wp_o;
  logic bp_req_o;
  logic [15:0] cnt0_o, cnt1_o, match0_o, match1_o;

  int checks = 0, errors = 0;
  logic [NW-1:0] m_wp = '0;
  logic m_bp = 0;
  logic [15:0] m_c0 = 0, m_c1 = 0, m_m0 = 0, m_m1 = 0;

  always #5 clk = ~clk;

  wpc_unit dut (.clk, .rst_n, .eval_i, .hit_i, .wp_mode_i, .cnt_sel_i, .cnt_en_i,
    .bp_mask_i, .cnt_wr_i, .cnt_val_i, .match_wr_i, .match_val_i,
    .wp_o, .bp_req_o, .cnt0_o, .cnt1_o, .match0_o, .match1_o);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "wp", 32'(wp_o), 32'(m_wp));
    chk(tag, "bp", 32'(bp_req_o), 32'(m_bp));
    chk(tag, "cnt0", 32'(cnt0_o), 32'(m_c0));
    chk(tag, "cnt1", 32'(cnt1_o), 32'(m_c1));
    chk(tag, "match0", 32'(match0_o), 32'(m_m0));
    chk(tag, "match1", 32'(match1_o), 32'(m_m1));
  endtask

  function automatic logic link(logic [1:0] c, logic a, logic b);
    if (c == 2'd0) return a;
    if (c == 2'd1) return a && b;
    if (c == 2'd2) return a || b;
    return 1'b0;
  endfunction

  task automatic model_step();
    logic [NW-1:0] nw;
    logic own, prev;
    int n0, n1;
    prev = hit_i[0];
    for (int n = 0; n < NW; n++) begin
      if (n < 8) own = hit_i[n];
      else if (n == 8) own = (m_c0 == m_m0);
      else if (n == 9) own = (m_c1 == m_m1);
      else own = hit_i[8];
      nw[n] = link(wp_mode_i[2*n +: 2], own, prev);
      prev = nw[n];
    end
    n0 = 0; n1 = 0; m_bp = 0;
    if (eval_i) begin
      for (int n = 0; n < NW; n++) if (nw[n] && !m_wp[n]) begin
        if (cnt_sel_i[n]) n1++; else n0++;
        if (bp_mask_i[n]) m_bp = 1;
      end
      m_wp = nw;
    end
    if (cnt_wr_i[0]) m_c0 = cnt_val_i; else if (cnt_en_i[0]) m_c0 = m_c0 + 16'(n0);
    if (cnt_wr_i[1]) m_c1 = cnt_val_i; else if (cnt_en_i[1]) m_c1 = m_c1 + 16'(n1);
    if (match_wr_i[0]) m_m0 = match_val_i;
    if (match_wr_i[1]) m_m1 = match_val_i;
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    eval_i = 0; cnt_wr_i = 0; match_wr_i = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    int unsigned r;
    seed = 32'h1234_5678;
    r = $urandom(seed);
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R7: load counter 0 and match 0
    cnt_wr_i = 2'b01; match_wr_i = 2'b01; cnt_val_i = 5; match_val_i = 5;
    step("R7");
    // R3: all links solo, no hits: wp8 and wp9 from counter compares
    wp_mode_i = '0; hit_i = 0; eval_i = 1;
    step("R3");
    hit_i = 9'h100; eval_i = 1;            // R3 external hit to wp10
    step("R3");
    // R2: clear, then cascade solo/AND/OR
    wp_mode_i = '1; eval_i = 1; step("R2");
    wp_mode_i = '1; wp_mode_i[5:0] = 6'b10_01_00;
    hit_i = 9'b001; eval_i = 1; step("R2");
    hit_i = 9'b011; eval_i = 1; step("R2");
    hit_i = 9'b100; eval_i = 1; step("R2");
    // R4: no evaluation holds the vector
    hit_i = 9'h1FF; step("R4");
    // R5: wrap of counter 1
    wp_mode_i = '1; eval_i = 1; step("R5");
    cnt_wr_i = 2'b10; match_wr_i = 2'b10; cnt_val_i = 16'hFFFF; match_val_i = 16'h0001;
    step("R7");
    wp_mode_i[1:0] = 2'd0; cnt_sel_i = 11'h001; cnt_en_i = 2'b10;
    hit_i = 9'b001; eval_i = 1; step("R5");
    bp_mask_i = 11'h001; eval_i = 1; step("R6");   // steady: no count, no request
    hit_i = 0; eval_i = 1; step("R6");
    hit_i = 9'b001; eval_i = 1; step("R6");        // rising with mask
    // R7: load wins over an increment
    hit_i = 0; eval_i = 1; step("R7");
    hit_i = 9'b001; eval_i = 1; cnt_wr_i = 2'b10; cnt_val_i = 16'h0040; step("R7");
    // R8: no evaluation: counters still, request low
    hit_i = 0; step("R8");
    hit_i = 9'b001; step("R8");

    for (int i = 0; i < 3000; i++) begin
      eval_i = ($urandom % 10) < 7;
      hit_i = 9'($urandom);
      for (int n = 0; n < NW; n++) wp_mode_i[2*n +: 2] = 2'($urandom % 4);
      cnt_sel_i = 11'($urandom);
      cnt_en_i = 2'($urandom);
      bp_mask_i = 11'($urandom);
      cnt_wr_i = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
      match_wr_i = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
      cnt_val_i = 16'($urandom % 4);
      match_val_i = 16'($urandom % 6);
      step("R5");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule